// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers up to 31 level-sensitive interrupt request lines for one processor core. Each line is captured into a raw pending register, and a software-written enable mask gates that register into a masked pending value. From the masked value the block drives two signals to the core: a request wire and an 8-bit vector bus. When exactly one enabled source is active, the vector identifies that source. When several enabled sources are active together, the block drives one shared vector. The handler then reads the masked pending value and applies its own priority order.

Software reaches the block through a small 32-bit word register port. The port has a writable enable mask and two read-only views: the raw pending bits and the masked pending bits. A mask write re-evaluates the request and vector outputs on the same clock edge that loads the mask. Masking the only active source therefore drops the request at once. A write to any offset other than the mask is flagged as an error and changes nothing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Out of reset, irqReq is 0, irqVector is 0, busErr is 0, busRdata is 0 and every mask bit is 0, so every source starts disabled.
- R2: Pending bit n-1 follows input line n (irqLines[n-1]) level by level. It is 1 while the line is high and 0 after the line goes low. A read at offset 0x4 returns the pending bits in positions 30..0, with bit 31 reading 0.
- R3: A read at offset 0x8 returns the raw pending bits ANDed with the mask, with bit 31 reading 0.
- R4: When exactly one masked pending bit is set, at position i (0 to 30), irqReq is 1 and irqVector is 0x31 + i.
- R5: When two or more masked pending bits are set, irqReq is 1 and irqVector is 0x30.
- R6: When no masked pending bit is set, irqReq is 0 and irqVector is 0. This holds whatever the lines do while their mask bits are 0.
- R7: A write at offset 0x0 loads busWdata[30:0] into the mask. On the next clock the outputs reflect the new mask, so clearing the mask bit of the only active source drops irqReq one cycle after the write.
- R8: irqReq and irqVector are registered. They change one clock after a line change and hold their old value until that edge.
- R9: A write to any offset other than 0x0 raises busErr for exactly the following cycle and leaves the mask unchanged. A write at 0x0 leaves busErr at 0.
- R10: Read data appears on busRdata in the cycle after the read request and is 0 in every other cycle. A read at 0x0 returns the mask with bit 31 reading 0, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irqLines | input | 31 | Level interrupt lines; line n is bit n-1 |
| busSel | input | 1 | Register access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the word accessed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse after a write to a non-writable offset |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 8 | Vector number to the core |

## Verification
The checker tests the same properties on every cycle. It checks that the request and vector outputs agree with the registered masked pending bits: zero when nothing is enabled, the shared vector for several sources, and a per-source vector for one. It also checks that pending follows the lines with one cycle of delay, that mask writes load the data, and that bad writes raise the error flag and leave the mask alone. Other behaviours can only be shown by the bench's scenarios. These are the exact per-source vector at both ends of the line range, the one-cycle drop after the last active source is masked, the read-back contents of each offset, and the old output value holding until the clock edge. A behavioural model, run alongside the design for every cycle of a random phase, covers mixed line and mask traffic.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  // Byte offsets of the word registers
  localparam int OFS_MASK   = 'h0;
  localparam int OFS_RAW    = 'h4;
  localparam int OFS_MASKED = 'h8;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic maskWr;    // load the enable mask from write data
    logic rdMask;    // capture mask into read data
    logic rdRaw;     // capture raw pending into read data
    logic rdMasked;  // capture masked pending into read data
  } ctlStrobe_t;

endpackage

// File: rtl/irq_vector_enc.sv
// Reduces the active (masked) bits to "any", "more than one" and the index
// of the single active bit. The index is only meaningful when exactly one
// bit is set, so it is built as an OR of per-bit position codes.
module irq_vector_enc #(
  parameter int NUM_SRC = 31,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] act,
  output logic               anyAct,
  output logic               manyAct,
  output logic [IDX_W-1:0]   oneIdx
);

  logic [IDX_W-1:0] partIdx [NUM_SRC];
  logic [NUM_SRC-1:0] lowCleared;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_idx
      if (i == 0) begin : g_first
        assign partIdx[i] = '0;
      end else begin : g_rest
        assign partIdx[i] = partIdx[i-1] | (act[i] ? IDX_W'(i) : '0);
      end
    end
  endgenerate

  // Clearing the lowest set bit leaves something only if two or more were set
  assign lowCleared = act & (act - NUM_SRC'(1));

  assign anyAct  = |act;
  assign manyAct = |lowCleared;
  assign oneIdx  = partIdx[NUM_SRC-1];

endmodule

// File: rtl/irq_vector_ctl.sv
// Register-port decoder: turns an access into datapath strobes and keeps
// the registered write-error flag.
module irq_vector_ctl
  import irq_vector_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strb,
  output logic              errQ
);

  logic hitMask, hitRaw, hitMasked;
  logic wrAcc, rdAcc;

  assign hitMask   = (busAddr == ADDR_W'(OFS_MASK));
  assign hitRaw    = (busAddr == ADDR_W'(OFS_RAW));
  assign hitMasked = (busAddr == ADDR_W'(OFS_MASKED));
  assign wrAcc     = busSel &  busWrite;
  assign rdAcc     = busSel & ~busWrite;

  always_comb begin
    strb          = '0;
    strb.maskWr   = wrAcc & hitMask;
    strb.rdMask   = rdAcc & hitMask;
    strb.rdRaw    = rdAcc & hitRaw;
    strb.rdMasked = rdAcc & hitMasked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errQ <= 1'b0;
    end else begin
      errQ <= wrAcc & ~hitMask;
    end
  end

endmodule

// File: rtl/irq_vector_dp.sv
// Datapath: pending and mask registers, read-data register and the
// registered request/vector outputs. Outputs are computed from the
// next-state pending and mask values so they land on the same edge.
module irq_vector_dp
  import irq_vector_pkg::*;
#(
  parameter int          NUM_SRC    = 31,
  parameter int          DATA_W     = 32,
  parameter int          VEC_W      = 8,
  parameter logic [7:0]  SHARED_VEC = 8'h30,
  parameter logic [7:0]  BASE_VEC   = 8'h31,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [DATA_W-1:0]  rdataQ,
  output logic               reqQ,
  output logic [VEC_W-1:0]   vecQ
);

  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] actNext;
  logic               anyAct, manyAct;
  logic [IDX_W-1:0]   oneIdx;
  logic [VEC_W-1:0]   vecNext;
  logic [DATA_W-1:0]  rdNext;

  assign maskNext = strb.maskWr ? busWdata[NUM_SRC-1:0] : maskQ;
  assign actNext  = irqLines & maskNext;

  irq_vector_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .act     (actNext),
    .anyAct  (anyAct),
    .manyAct (manyAct),
    .oneIdx  (oneIdx)
  );

  always_comb begin
    if (manyAct)     vecNext = VEC_W'(SHARED_VEC);
    else if (anyAct) vecNext = VEC_W'(BASE_VEC) + VEC_W'(oneIdx);
    else             vecNext = '0;
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdMask)   rdNext = DATA_W'(maskQ);
    if (strb.rdRaw)    rdNext = DATA_W'(pendQ);
    if (strb.rdMasked) rdNext = DATA_W'(pendQ & maskQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ  <= '0;
      pendQ  <= '0;
      rdataQ <= '0;
      reqQ   <= 1'b0;
      vecQ   <= '0;
    end else begin
      maskQ  <= maskNext;
      pendQ  <= irqLines;
      rdataQ <= rdNext;
      reqQ   <= anyAct;
      vecQ   <= vecNext;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int          NUM_SRC    = 31,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          VEC_W      = 8,
  parameter logic [7:0]  SHARED_VEC = 8'h30,
  parameter logic [7:0]  BASE_VEC   = 8'h31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               busErr,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector
);

  ctlStrobe_t         strb;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] pendQ;

  irq_vector_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .errQ     (busErr)
  );

  irq_vector_dp #(
    .NUM_SRC    (NUM_SRC),
    .DATA_W     (DATA_W),
    .VEC_W      (VEC_W),
    .SHARED_VEC (SHARED_VEC),
    .BASE_VEC   (BASE_VEC)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .busWdata (busWdata),
    .irqLines (irqLines),
    .maskQ    (maskQ),
    .pendQ    (pendQ),
    .rdataQ   (busRdata),
    .reqQ     (irqReq),
    .vecQ     (irqVector)
  );

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int          NUM_SRC    = 31,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          VEC_W      = 8,
  parameter logic [7:0]  SHARED_VEC = 8'h30,
  parameter logic [7:0]  BASE_VEC   = 8'h31
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irqLines,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               busErr,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVector,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] pendQ
);

  logic [NUM_SRC-1:0] live;
  assign live = pendQ & maskQ;

  // R4
  single_vec_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(live) == 1) |-> (irqReq && irqVector >= VEC_W'(BASE_VEC)
                                 && irqVector < VEC_W'(BASE_VEC) + VEC_W'(NUM_SRC)));

  // R5
  shared_vec_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(live) > 1) |-> (irqReq && irqVector == VEC_W'(SHARED_VEC)));

  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(live) == 0) |-> (!irqReq && irqVector == '0));

  // R2
  pend_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pendQ == $past(irqLines)));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && busAddr == '0) |=> (maskQ == $past(busWdata[NUM_SRC-1:0]) && !busErr));

  // R9
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && busAddr != '0) |=> (busErr && $stable(maskQ)));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(busSel && busWrite && busAddr != '0) |=> !busErr);

endmodule

bind irq_vector_ctrl irq_vector_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
  .SHARED_VEC(SHARED_VEC), .BASE_VEC(BASE_VEC)
) u_chk (
  .clk(clk), .rst(rst), .irqLines(irqLines), .busSel(busSel),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .busErr(busErr), .irqReq(irqReq), .irqVector(irqVector),
  .maskQ(maskQ), .pendQ(pendQ)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  localparam int NS = 31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [30:0] irqLines = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        irqReq;
  logic [7:0]  irqVector;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .irqLines(irqLines), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .irqReq(irqReq),
    .irqVector(irqVector)
  );

  // Behavioural reference model
  logic [30:0] mMask, mPend, nm, act;
  logic        mReq, mErr;
  logic [7:0]  mVec;
  logic [31:0] mRd;
  int cnt, first;

  always @(posedge clk) begin
    if (rst) begin
      mMask <= '0; mPend <= '0; mReq <= 0; mVec <= '0; mRd <= '0; mErr <= 0;
    end else begin
      nm = (busSel && busWrite && busAddr == 8'h0) ? busWdata[30:0] : mMask;
      act = irqLines & nm;
      cnt = 0; first = 0;
      for (int i = 0; i < NS; i++)
        if (act[i]) begin
          if (cnt == 0) first = i;
          cnt++;
        end
      mReq <= (cnt != 0);
      mVec <= (cnt == 0) ? 8'h00 : (cnt == 1) ? 8'(8'h31 + first) : 8'h30;
      if (busSel && !busWrite)
        mRd <= (busAddr == 8'h0) ? {1'b0, mMask} :
               (busAddr == 8'h4) ? {1'b0, mPend} :
               (busAddr == 8'h8) ? {1'b0, mPend & mMask} : 32'h0;
      else
        mRd <= 32'h0;
      mErr <= busSel && busWrite && (busAddr != 8'h0);
      mMask <= nm;
      mPend <= irqLines;
    end
  end

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, actual, expected, $time);
    end
  endtask

  // Per-cycle model comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      string vt;
      vt = rst ? "R1" : (mVec == 8'h0) ? "R6" : (mVec == 8'h30) ? "R5" : "R4";
      chk({vt, " irqReq"}, 32'(irqReq), 32'(mReq));
      chk({vt, " irqVector"}, 32'(irqVector), 32'(mVec));
      chk(rst ? "R1 busRdata" : "R10 busRdata", busRdata, mRd);
      chk(rst ? "R1 busErr" : "R9 busErr", 32'(busErr), 32'(mErr));
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    d = busRdata;
  endtask

  task automatic setLines(input logic [30:0] v);
    @(negedge clk);
    irqLines = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req", 32'(irqReq), 0);
    chk("R1 vec", 32'(irqVector), 0);
    rst = 0;
    rdReg(8'h0, rd); chk("R1 mask after reset", rd, 32'h0);

    // R6: lines active but all masked off
    setLines(31'h0000_0005);
    chk("R6 masked-off req", 32'(irqReq), 0);
    chk("R6 masked-off vec", 32'(irqVector), 0);
    // R2: raw pending read, line 1 -> bit 0, line 3 -> bit 2
    rdReg(8'h4, rd); chk("R2 raw pending", rd, 32'h0000_0005);

    // R10: mask read-back drops bit 31
    wrReg(8'h0, 32'hFFFF_FFFF);
    rdReg(8'h0, rd); chk("R10 mask readback", rd, 32'h7FFF_FFFF);
    // R5: two enabled sources -> shared vector
    chk("R5 shared vec", 32'(irqVector), 32'h30);
    // R3: masked read
    wrReg(8'h0, 32'h0000_0004);
    rdReg(8'h8, rd); chk("R3 masked pending", rd, 32'h0000_0004);
    // R4: only bit 2 enabled
    chk("R4 vec bit2", 32'(irqVector), 32'h33);
    chk("R4 req", 32'(irqReq), 1);

    // R7: masking the only active source drops the request next cycle
    wrReg(8'h0, 32'h0000_0001);
    chk("R7 req after unmask", 32'(irqReq), 1);
    chk("R7 vec after unmask", 32'(irqVector), 32'h31);
    wrReg(8'h0, 32'h0000_0000);
    chk("R7 req dropped", 32'(irqReq), 0);

    // R4 boundary: highest source, line 31 -> bit 30
    wrReg(8'h0, 32'h7FFF_FFFF);
    setLines(31'h4000_0000);
    chk("R4 vec bit30", 32'(irqVector), 32'h4F);

    // R8: output holds until the edge, then changes
    @(negedge clk);
    irqLines = 31'h0000_0000;
    #1 chk("R8 hold before edge", 32'(irqReq), 1);
    @(negedge clk);
    chk("R8 update after edge", 32'(irqReq), 0);
    // R2: pending bit clears when line drops
    rdReg(8'h4, rd); chk("R2 pending cleared", rd, 32'h0);

    // R9: write to a read-only offset is an error and leaves mask intact
    wrReg(8'h4, 32'h0000_00F0);
    chk("R9 err pulse", 32'(busErr), 1);
    @(negedge clk);
    chk("R9 err one cycle", 32'(busErr), 0);
    rdReg(8'h0, rd); chk("R9 mask unchanged", rd, 32'h7FFF_FFFF);
    // R10: unmapped read returns zero
    rdReg(8'h0C, rd); chk("R10 unmapped read", rd, 32'h0);

    // Random traffic against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      case ($urandom_range(0, 3))
        0: irqLines = 31'(1 << $urandom_range(0, 30));
        1: irqLines = 31'($urandom);
        2: irqLines = '0;
        default: ;
      endcase
      busSel = ($urandom_range(0, 2) == 0);
      busWrite = $urandom_range(0, 1);
      busAddr = 8'($urandom_range(0, 4) * 4);
      busWdata = ($urandom_range(0, 1) == 1) ? $urandom : 32'(1 << $urandom_range(0, 31));
    end
    @(negedge clk);
    busSel = 0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule